// File: doc/BRIEF.md
# Serial Converter Control Word Capture and Power Sequencer

This block is the digital front end of a serial-interface converter. A host frames each transfer with an active-low chip select and sends sixteen serial clocks. The block takes the first eight data bits, most significant first, as the new control word. It holds that word in a write-only register and decodes the fields the converter needs: whether the on-chip reference is enabled, whether the part runs with one input or two, and which input is converted next.

A power sequencer uses the 2-bit power field of the register to choose among shutdown, standby and full power. Depending on that field, it follows the chip-select level, stays on at all times, or drops power when the converter core signals that a conversion has finished. The serial pins are asynchronous to the block clock, so they pass through a synchronizer before any edge is detected. The conversion-done strobe comes from the converter core and is already in the block clock domain.

All pins are plain control and status signals. There is no streamed data path, so there is no valid/ready handshake and no back-pressure.

Top module: `sadc_ctl_top`

## Requirements
- R1: After reset the control word is all zeros. As a result, `ref_en`=1, `dual_mode`=0, `chan_sel`=0, `pwr_mode`=00 and, with chip select high, `pwr_state`=00.
- R2: The word is taken MSB first from `sdi` on the first eight rising `sclk` edges after `cs_n` falls. The outputs change only once the eighth edge has been seen. Edges 9 to 16 of the same transfer have no effect.
- R3: If `cs_n` rises before the eighth rising edge, the transfer is dropped and every decoded output keeps its previous value.
- R4: Word bit 5 is the reference-off bit: `ref_en` = NOT bit 5.
- R5: Word bit 4 selects dual-input mode (`dual_mode`). Word bit 3 selects input 1 (`chan_sel`) only while bit 4 is 1. In single-input mode `chan_sel` is 0.
- R6: Word bits 7, 6 and 2 do not affect any output.
- R7: `pwr_mode` presents word bits 1:0. `pwr_state` is encoded as 00 shutdown, 01 standby and 10 full power, and it never takes the value 11. In mode 00 the state is full power while `cs_n` is low and shutdown while `cs_n` is high.
- R8: In mode 01 the state is full power whatever `cs_n` and `conv_done` do.
- R9: In mode 10 a `conv_done` pulse moves the state to shutdown, whether `cs_n` is high or low. A falling `cs_n` moves it to full power.
- R10: In mode 11 a `conv_done` pulse moves the state to standby. A falling `cs_n` moves it to full power.
- R11: In modes 10 and 11, if a `cs_n` fall and a `conv_done` pulse are seen in the same cycle, the state goes to full power.
- R12: A change on `sclk`, `cs_n` or `sdi` reaches the outputs in the third clock cycle after it. The latency is SYNC_STAGES (2) cycles of synchronizer plus one register. A `conv_done` pulse changes `pwr_state` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; samples all serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host, asynchronous |
| cs_n | input | 1 | Active-low chip select framing a transfer, asynchronous |
| sdi | input | 1 | Serial data in, MSB first |
| conv_done | input | 1 | One-cycle end-of-conversion strobe from the converter core |
| ref_en | output | 1 | On-chip reference enabled |
| dual_mode | output | 1 | Two-input mode selected |
| chan_sel | output | 1 | Input to convert next (0 or 1) |
| pwr_mode | output | 2 | Current power-mode field |
| pwr_state | output | 2 | Power state: 00 shutdown, 01 standby, 10 full power |

## Verification
Serial-pin results are due in the third block-clock cycle after the pin changes. A `conv_done` result is due one cycle after the strobe. The bench drives every stimulus one time unit after a rising edge. It posts the expected output vector to the scoreboard only after counting exactly that many rising edges, and the monitor compares at the next falling edge. For the latency requirement, the bench also posts the old value one edge early, so an output that is a cycle too fast or a cycle too slow is reported.

// File: rtl/sadc_ctl_pkg.sv
package sadc_ctl_pkg;

  // bit positions inside the control word; the host relies on these
  localparam int unsigned POS_REF_OFF = 5;
  localparam int unsigned POS_DUAL    = 4;
  localparam int unsigned POS_CHAN    = 3;
  localparam int unsigned POS_PM_HI   = 1;
  localparam int unsigned POS_PM_LO   = 0;

  typedef enum logic [1:0] {
    PWR_OFF  = 2'b00,
    PWR_STBY = 2'b01,
    PWR_FULL = 2'b10
  } pwr_state_e;

  typedef enum logic [1:0] {
    PM_CS_GATED  = 2'b00,
    PM_ALWAYS_ON = 2'b01,
    PM_AUTO_OFF  = 2'b10,
    PM_AUTO_STBY = 2'b11
  } pm_e;

  // only the fields that drive something are stored
  typedef struct packed {
    logic       ref_off;
    logic       dual;
    logic       chan;
    logic [1:0] pm;
  } ctl_fields_t;

endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
  parameter int unsigned W          = 3,
  parameter int unsigned STAGES     = 2,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RESET_VAL;
    end else begin
      pipe[0] <= d_in;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/sadc_frame_rx.sv
module sadc_frame_rx
  import sadc_ctl_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_low,
  input  logic        cs_fall,
  input  logic        sclk_rise,
  input  logic        sdi,
  output ctl_fields_t ctl,
  output logic        load
);

  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W);

  logic [CNT_W-1:0] bit_cnt;
  logic [CNT_W-1:0] bit_pos;
  ctl_fields_t      stage_q, stage_d;
  logic             take;

  // a bit is taken only inside a frame and only up to the word width
  assign take    = cs_low && sclk_rise && (bit_cnt < CNT_MAX);
  assign bit_pos = CNT_MAX - CNT_W'(1) - bit_cnt;
  assign load    = take && (bit_cnt == CNT_MAX - CNT_W'(1));

  // steer the incoming bit straight into the field it belongs to
  always_comb begin
    stage_d = stage_q;
    if (take) begin
      if (bit_pos == CNT_W'(POS_REF_OFF)) stage_d.ref_off = sdi;
      if (bit_pos == CNT_W'(POS_DUAL))    stage_d.dual    = sdi;
      if (bit_pos == CNT_W'(POS_CHAN))    stage_d.chan    = sdi;
      if (bit_pos == CNT_W'(POS_PM_HI))   stage_d.pm[1]   = sdi;
      if (bit_pos == CNT_W'(POS_PM_LO))   stage_d.pm[0]   = sdi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      stage_q <= '0;
      ctl     <= '0;
    end else begin
      if (cs_fall)   bit_cnt <= '0;
      else if (take) bit_cnt <= bit_cnt + CNT_W'(1);
      stage_q <= stage_d;
      if (load && !cs_fall) ctl <= stage_d;
    end
  end

endmodule

// File: rtl/sadc_pwr_fsm.sv
module sadc_pwr_fsm
  import sadc_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pm_e        pm,
  input  logic       cs_low,
  input  logic       cs_fall,
  input  logic       conv_done,
  output pwr_state_e state
);

  pwr_state_e state_d;

  always_comb begin
    state_d = state;
    unique case (pm)
      PM_CS_GATED:  state_d = cs_low ? PWR_FULL : PWR_OFF;
      PM_ALWAYS_ON: state_d = PWR_FULL;
      PM_AUTO_OFF: begin
        if (cs_fall)        state_d = PWR_FULL;
        else if (conv_done) state_d = PWR_OFF;
      end
      PM_AUTO_STBY: begin
        if (cs_fall)        state_d = PWR_FULL;
        else if (conv_done) state_d = PWR_STBY;
      end
      default: state_d = PWR_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PWR_OFF;
    else        state <= state_d;
  end

endmodule

// File: rtl/sadc_ctl_top.sv
module sadc_ctl_top
  import sadc_ctl_pkg::*;
#(
  parameter int unsigned WORD_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       sdi,
  input  logic       conv_done,
  output logic       ref_en,
  output logic       dual_mode,
  output logic       chan_sel,
  output logic [1:0] pwr_mode,
  output logic [1:0] pwr_state
);

  localparam logic [2:0] PIN_IDLE = 3'b010; // sclk low, cs_n high, sdi low

  logic [2:0]  pins_q;
  logic        sclk_s, cs_n_s, sdi_s;
  logic        sclk_prev, cs_n_prev;
  logic        sclk_rise, cs_fall, cs_low;
  logic        load;
  ctl_fields_t ctl;
  pwr_state_e  state;

  sadc_sync #(
    .W(3), .STAGES(SYNC_STAGES), .RESET_VAL(PIN_IDLE)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_in ({sclk, cs_n, sdi}),
    .q    (pins_q)
  );

  assign {sclk_s, cs_n_s, sdi_s} = pins_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev <= 1'b0;
      cs_n_prev <= 1'b1;
    end else begin
      sclk_prev <= sclk_s;
      cs_n_prev <= cs_n_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_prev;
  assign cs_fall   = ~cs_n_s & cs_n_prev;
  assign cs_low    = ~cs_n_s;

  sadc_frame_rx #(.WORD_W(WORD_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_low   (cs_low),
    .cs_fall  (cs_fall),
    .sclk_rise(sclk_rise),
    .sdi      (sdi_s),
    .ctl      (ctl),
    .load     (load)
  );

  sadc_pwr_fsm u_pwr (
    .clk      (clk),
    .rst_n    (rst_n),
    .pm       (pm_e'(ctl.pm)),
    .cs_low   (cs_low),
    .cs_fall  (cs_fall),
    .conv_done(conv_done),
    .state    (state)
  );

  assign ref_en    = ~ctl.ref_off;
  assign dual_mode = ctl.dual;
  assign chan_sel  = ctl.dual & ctl.chan;
  assign pwr_mode  = ctl.pm;
  assign pwr_state = state;

endmodule

// File: rtl/sadc_ctl_chk.sv
module sadc_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_low,
  input logic       cs_fall,
  input logic       load,
  input logic       conv_done,
  input logic       ref_en,
  input logic       dual_mode,
  input logic       chan_sel,
  input logic [1:0] pwr_mode,
  input logic [1:0] pwr_state
);

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state != 2'b11); // R7

  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable({ref_en, dual_mode, chan_sel, pwr_mode})); // R3

  AST_GATED_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'b00 && cs_low) |=> pwr_state == 2'b10); // R7

  AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'b00 && !cs_low) |=> pwr_state == 2'b00); // R7

  AST_ALWAYS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'b01) |=> pwr_state == 2'b10); // R8

  AST_AUTO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'b10 && conv_done && !cs_fall) |=> pwr_state == 2'b00); // R9

  AST_AUTO_STBY: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'b11 && conv_done && !cs_fall) |=> pwr_state == 2'b01); // R10

  AST_WAKE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode[1] && cs_fall) |=> pwr_state == 2'b10); // R11

endmodule

bind sadc_ctl_top sadc_ctl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_low   (cs_low),
  .cs_fall  (cs_fall),
  .load     (load),
  .conv_done(conv_done),
  .ref_en   (ref_en),
  .dual_mode(dual_mode),
  .chan_sel (chan_sel),
  .pwr_mode (pwr_mode),
  .pwr_state(pwr_state)
);

// File: tb/sadc_ctl_top_tb_top.sv
`timescale 1ns/1ps
module sadc_ctl_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n, sclk, cs_n, sdi, conv_done;
  logic       ref_en, dual_mode, chan_sel;
  logic [1:0] pwr_mode, pwr_state;

  localparam logic [1:0] ST_OFF  = 2'b00;
  localparam logic [1:0] ST_STBY = 2'b01;
  localparam logic [1:0] ST_FULL = 2'b10;

  always #2.5 clk = ~clk;

  sadc_ctl_top dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .conv_done(conv_done), .ref_en(ref_en), .dual_mode(dual_mode),
    .chan_sel(chan_sel), .pwr_mode(pwr_mode), .pwr_state(pwr_state)
  );

  typedef struct {
    string      req;
    logic [6:0] val;
  } item_t;

  item_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // expected output vector {ref_en, dual_mode, chan_sel, pwr_mode, pwr_state}
  function automatic logic [6:0] expv(logic [7:0] w, logic [1:0] st);
    return {~w[5], w[4], w[4] & w[3], w[1:0], st};
  endfunction

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push(string r, logic [6:0] v);
    item_t it;
    it.req = r;
    it.val = v;
    q.push_back(it);
  endtask

  // monitor: compares pending expectations half a cycle after they are posted
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_cmp++;
        if ({ref_en, dual_mode, chan_sel, pwr_mode, pwr_state} !== it.val) begin
          n_bad++;
          $display("FAIL %s: got %b expected %b", it.req,
                   {ref_en, dual_mode, chan_sel, pwr_mode, pwr_state}, it.val);
        end
      end
    end
  end

  // one framed transfer; bits beyond the control byte are all ones
  task automatic send(logic [7:0] w, int nclk, string mid_req, logic [6:0] mid_exp);
    logic [15:0] bits;
    bits = {w, 8'hFF};
    cs_n = 1'b0;
    tick(6);
    for (int i = 0; i < nclk; i++) begin
      sdi = bits[15-i];
      tick(3);
      sclk = 1'b1;
      tick(3);
      if (i == 7 && mid_req != "") push(mid_req, mid_exp);
      sclk = 1'b0;
    end
    tick(3);
    cs_n = 1'b1;
    tick(6);
  endtask

  task automatic pulse_done();
    conv_done = 1'b1;
    tick(1);
    conv_done = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; sdi = 1'b0; conv_done = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(2);
    push("R1 reset state", expv(8'h00, ST_OFF));
    tick(1);

    // R7 / R12: mode 00 follows chip select, three-cycle latency
    cs_n = 1'b0;
    tick(2);
    push("R12 cs fall not yet visible", expv(8'h00, ST_OFF));
    tick(1);
    push("R7 R12 mode00 full on cs low", expv(8'h00, ST_FULL));
    cs_n = 1'b1;
    tick(2);
    push("R12 cs rise not yet visible", expv(8'h00, ST_FULL));
    tick(1);
    push("R7 mode00 off on cs high", expv(8'h00, ST_OFF));

    // R2 R4 R5: reference off, dual, input 0
    send(8'h30, 16, "R2 word applied after eighth edge", expv(8'h30, ST_FULL));
    push("R4 R5 word 30 decoded", expv(8'h30, ST_OFF));
    // R5 with trailing ones ignored (R2)
    send(8'h38, 16, "", 7'b0);
    push("R2 R5 dual input 1, trailing bits ignored", expv(8'h38, ST_OFF));
    // R5: single mode forces input 0
    send(8'h28, 16, "", 7'b0);
    push("R5 single mode forces input 0", 7'b0_0_0_00_00);

    // R6 R8: don't-care bits set, always-on mode
    send(8'hC5, 16, "", 7'b0);
    push("R6 bits 7 6 2 ignored, R8 on with cs high", expv(8'h01, ST_FULL));
    pulse_done();
    push("R8 conv_done has no effect", expv(8'h01, ST_FULL));

    // R3: aborted transfer
    send(8'h3A, 5, "", 7'b0);
    push("R3 aborted transfer leaves word", expv(8'h01, ST_FULL));

    // R9: auto shutdown
    send(8'h02, 16, "", 7'b0);
    push("R9 mode10 holds full after load", expv(8'h02, ST_FULL));
    pulse_done();
    push("R9 R12 conv_done shuts down next cycle", expv(8'h02, ST_OFF));
    cs_n = 1'b0;
    tick(2);
    push("R12 wake not yet visible", expv(8'h02, ST_OFF));
    tick(1);
    push("R9 cs fall wakes", expv(8'h02, ST_FULL));
    tick(2);
    pulse_done();
    push("R9 conv_done shuts down with cs low", expv(8'h02, ST_OFF));
    cs_n = 1'b1;
    tick(6);
    push("R9 cs rise has no effect", expv(8'h02, ST_OFF));

    // R10: auto standby
    send(8'h03, 16, "", 7'b0);
    push("R10 mode11 full after frame", expv(8'h03, ST_FULL));
    pulse_done();
    push("R10 conv_done enters standby", expv(8'h03, ST_STBY));
    cs_n = 1'b0;
    tick(3);
    push("R10 cs fall wakes from standby", expv(8'h03, ST_FULL));
    cs_n = 1'b1;
    tick(6);
    pulse_done();
    push("R10 back to standby", expv(8'h03, ST_STBY));

    // R11: wake and end of conversion in the same cycle
    cs_n = 1'b0;
    tick(2);
    conv_done = 1'b1;
    tick(1);
    conv_done = 1'b0;
    push("R11 wake wins over conv_done", expv(8'h03, ST_FULL));
    cs_n = 1'b1;
    tick(6);

    wait (q.size() == 0);
    tick(2);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule